// File: doc/BRIEF.md
# Inbound DMA Window Translator

This block turns an address that a device places on its bus during an inbound DMA request into a system memory address. The bus address space holds five windows. Two direct windows build the system address from the bus address alone: a fixed pass-through of the low 54 bits, or a splice with a per-port upper-address base. Three page-mapped windows look the page number up in a translation table and add the in-page offset. The 32-bit windows and the 64-bit direct window carry a barrier attribute bit. The block removes that bit from the address and reports it on its own output. The two 40-bit windows have no barrier bit.

Software loads the tables and the two direct-map base registers through a single write port. The shared table serves two windows. Its lowest 64 entries hold super-page translations, split by port, and the entries above them hold 256 KB page translations. A separate table holds the 64 MB page translations. Each request is answered one clock later with the translated address, the barrier flag, a window code and a fault flag.

Top module: `dxl_top`

## Requirements
- R1: With bus bit 63 set, the request is in the 64-bit direct window (window code 1). The system address is bus bits 53:0 with all upper bits zero. The barrier flag is bus bit 62, and bus bit 61 has no effect on the result.
- R2: In the 64-bit direct window, any nonzero bit among bus bits 60:54 raises the fault.
- R3: Bus addresses 0x8000_0000 to 0xFFFF_FFFF form the 32-bit direct window (code 2). The result is the base register of the requesting port, bits 63:30, joined with bus bits 29:0. Bus bit 30 is the barrier flag and does not appear in the address.
- R4: Bus addresses 0x0 to 0x7FFF_FFFF form the 32-bit page window (code 3). Bus bit 30 is the barrier flag. The page number is bus bits 29:18, and it reads shared entry 64 + page. The result is the entry's bits 62:18 above bus bits 17:0. A page at or beyond SH_DEPTH-64 faults.
- R5: Bus addresses 0x40_0000_0000 to 0x7F_FFFF_FFFF form the 40-bit page window (code 4). The page number is bus bits 37:26 and indexes the large table. The result is the entry's bits 62:26 above bus bits 25:0. The barrier flag is always 0, and a page at or beyond LG_DEPTH faults.
- R6: Bus addresses 0x80_0000_0000 to 0xFF_FFFF_FFFF form the super-page window (code 5). It reads shared entry port*32 + bus bits 38:34. The result is the entry's bits 62:34 above bus bits 33:0, and the barrier flag is always 0.
- R7: A table entry is valid only when its bit 63 is set. A page-window lookup that reads an invalid entry faults.
- R8: Any other bus address matches no window. It returns window code 0 with the fault set.
- R9: Whenever the fault is set, the address and the barrier flag are zero.
- R10: The response valid is high exactly in the cycle after a request. The response fields hold their values until the next request.
- R11: A write with cfg_tbl 0 goes to a shared entry, 1 to a large-table entry, and 2 to the base register of port cfg_idx (0 or 1). Code 3 has no effect. A request in the same cycle as a write sees the old value, and a request in the next cycle sees the new one.
- R12: Reset invalidates every table entry and zeroes both base registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request strobe |
| req_addr | input | 64 | Bus address to translate |
| req_port | input | 1 | Requesting port (0 or 1) |
| cfg_we | input | 1 | Table write strobe |
| cfg_tbl | input | 2 | Write target: 0 shared, 1 large, 2 base, 3 none |
| cfg_idx | input | 7 | Entry index or base port number |
| cfg_wdata | input | 64 | Write data |
| rsp_vld | output | 1 | Response valid, one cycle after the request |
| rsp_addr | output | 64 | Translated system address |
| rsp_barrier | output | 1 | Barrier attribute taken from the bus address |
| rsp_win | output | 3 | Window code |
| rsp_fault | output | 1 | Translation fault |

## Verification
A table write and a lookup of the same entry can fall in the same clock cycle. The bench provokes this by raising cfg_we and req_vld together on an entry that is still invalid. It expects a fault from that lookup and a correct translation from an identical lookup one cycle later. The bench also separates the two ports in the super-page and direct windows by giving the same bus address a different result per port. It checks each window at a page boundary where out-of-range pages must fault.

// File: rtl/dxl_pkg.sv
package dxl_pkg;

    localparam int NUM_PORTS      = 2;
    localparam int ENTRY_VALID    = 63;
    localparam int D64_LOW_W      = 54;
    localparam int D32_SPLIT      = 30;
    localparam int P32_SHIFT      = 18;
    localparam int P40_SHIFT      = 26;
    localparam int SUP_SHIFT      = 34;
    localparam int SUP_PER_PORT   = 32;
    localparam int SUP_RESERVED   = 64;

    typedef enum logic [2:0] {
        WIN_NONE  = 3'd0,
        WIN_D64   = 3'd1,
        WIN_D32   = 3'd2,
        WIN_P32   = 3'd3,
        WIN_P40   = 3'd4,
        WIN_SUPER = 3'd5
    } win_e;

    typedef enum logic [1:0] {
        TBL_SHARED = 2'd0,
        TBL_LARGE  = 2'd1,
        TBL_BASE   = 2'd2,
        TBL_NONE   = 2'd3
    } tbl_e;

    typedef struct packed {
        win_e        win;
        logic        barrier;
        logic        dfault;
        logic [63:0] offset;
    } dec_t;

    typedef struct packed {
        logic [63:0] addr;
        logic        barrier;
        win_e        win;
        logic        fault;
    } rsp_t;

    function automatic logic [63:0] low_mask(input int bits);
        return (64'd1 << bits) - 64'd1;
    endfunction

    function automatic logic [63:0] page_base(input logic [63:0] entry, input int shift);
        return {1'b0, entry[62:0]} & ~low_mask(shift);
    endfunction

endpackage

// File: rtl/dxl_decode.sv
module dxl_decode
    import dxl_pkg::*;
#(
    parameter int SH_DEPTH = 128,
    parameter int LG_DEPTH = 64,
    parameter int SH_IW    = 7,
    parameter int LG_IW    = 6
) (
    input  logic [63:0]      addr,
    input  logic             port,
    output dec_t             dec,
    output logic [SH_IW-1:0] sh_idx,
    output logic [LG_IW-1:0] lg_idx
);

    logic [11:0] pg32;
    logic [11:0] pg40;
    logic [4:0]  pgsup;

    assign pg32  = addr[29:P32_SHIFT];
    assign pg40  = addr[37:P40_SHIFT];
    assign pgsup = addr[38:SUP_SHIFT];

    always_comb begin
        dec        = '{win: WIN_NONE, barrier: 1'b0, dfault: 1'b1, offset: 64'd0};
        sh_idx     = '0;
        lg_idx     = '0;
        if (addr[63]) begin
            dec.win     = WIN_D64;
            dec.barrier = addr[62];
            dec.dfault  = |addr[60:D64_LOW_W];
            dec.offset  = addr & low_mask(D64_LOW_W);
        end else if (addr[62:32] == '0 && addr[31]) begin
            dec.win     = WIN_D32;
            dec.barrier = addr[30];
            dec.dfault  = 1'b0;
            dec.offset  = addr & low_mask(D32_SPLIT);
        end else if (addr[62:31] == '0) begin
            dec.win     = WIN_P32;
            dec.barrier = addr[30];
            dec.dfault  = (32'(pg32) >= SH_DEPTH - SUP_RESERVED);
            dec.offset  = addr & low_mask(P32_SHIFT);
            sh_idx      = SH_IW'(SUP_RESERVED + 32'(pg32));
        end else if (addr[62:40] == '0 && addr[39]) begin
            dec.win     = WIN_SUPER;
            dec.dfault  = 1'b0;
            dec.offset  = addr & low_mask(SUP_SHIFT);
            sh_idx      = SH_IW'(32'(port) * SUP_PER_PORT + 32'(pgsup));
        end else if (addr[62:40] == '0 && addr[38]) begin
            dec.win     = WIN_P40;
            dec.dfault  = (32'(pg40) >= LG_DEPTH);
            dec.offset  = addr & low_mask(P40_SHIFT);
            lg_idx      = LG_IW'(pg40);
        end
    end

endmodule

// File: rtl/dxl_tables.sv
module dxl_tables
    import dxl_pkg::*;
#(
    parameter int SH_DEPTH = 128,
    parameter int LG_DEPTH = 64,
    parameter int SH_IW    = 7,
    parameter int LG_IW    = 6,
    parameter int IDX_W    = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_tbl,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [63:0]      cfg_wdata,
    input  logic [SH_IW-1:0] sh_ridx,
    input  logic [LG_IW-1:0] lg_ridx,
    input  logic             port,
    output logic [63:0]      sh_entry,
    output logic [63:0]      lg_entry,
    output logic [63:0]      dir_base
);

    logic [63:0] sh_mem [SH_DEPTH];
    logic [63:0] lg_mem [LG_DEPTH];
    logic [63:0] base_q [NUM_PORTS];

    tbl_e tsel;
    assign tsel = tbl_e'(cfg_tbl);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SH_DEPTH; i++) sh_mem[i] <= '0;
        end else if (cfg_we && tsel == TBL_SHARED && 32'(cfg_idx) < SH_DEPTH) begin
            sh_mem[SH_IW'(cfg_idx)] <= cfg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LG_DEPTH; i++) lg_mem[i] <= '0;
        end else if (cfg_we && tsel == TBL_LARGE && 32'(cfg_idx) < LG_DEPTH) begin
            lg_mem[LG_IW'(cfg_idx)] <= cfg_wdata;
        end
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_base
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[g] <= '0;
            end else if (cfg_we && tsel == TBL_BASE && cfg_idx == IDX_W'(g)) begin
                base_q[g] <= cfg_wdata & ~low_mask(D32_SPLIT);
            end
        end
    end

    assign sh_entry = sh_mem[sh_ridx];
    assign lg_entry = lg_mem[lg_ridx];
    assign dir_base = base_q[port];

endmodule

// File: rtl/dxl_compose.sv
module dxl_compose
    import dxl_pkg::*;
(
    input  dec_t        dec,
    input  logic [63:0] sh_entry,
    input  logic [63:0] lg_entry,
    input  logic [63:0] dir_base,
    output rsp_t        rsp
);

    logic        flt;
    logic [63:0] addr;

    always_comb begin
        flt  = dec.dfault;
        addr = '0;
        unique case (dec.win)
            WIN_D64:   addr = dec.offset;
            WIN_D32:   addr = (dir_base & ~low_mask(D32_SPLIT)) | dec.offset;
            WIN_P32: begin
                flt  = flt | ~sh_entry[ENTRY_VALID];
                addr = page_base(sh_entry, P32_SHIFT) | dec.offset;
            end
            WIN_SUPER: begin
                flt  = flt | ~sh_entry[ENTRY_VALID];
                addr = page_base(sh_entry, SUP_SHIFT) | dec.offset;
            end
            WIN_P40: begin
                flt  = flt | ~lg_entry[ENTRY_VALID];
                addr = page_base(lg_entry, P40_SHIFT) | dec.offset;
            end
            default:   flt = 1'b1;
        endcase
        rsp.win     = dec.win;
        rsp.fault   = flt;
        rsp.addr    = flt ? 64'd0 : addr;
        rsp.barrier = flt ? 1'b0 : dec.barrier;
    end

endmodule

// File: rtl/dxl_top.sv
module dxl_top
    import dxl_pkg::*;
#(
    parameter int SH_DEPTH = 128,
    parameter int LG_DEPTH = 64,
    localparam int SH_IW   = $clog2(SH_DEPTH),
    localparam int LG_IW   = $clog2(LG_DEPTH),
    localparam int IDX_W   = (SH_IW > LG_IW) ? SH_IW : LG_IW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_vld,
    input  logic [63:0]      req_addr,
    input  logic             req_port,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_tbl,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [63:0]      cfg_wdata,
    output logic             rsp_vld,
    output logic [63:0]      rsp_addr,
    output logic             rsp_barrier,
    output logic [2:0]       rsp_win,
    output logic             rsp_fault
);

    dec_t             dec;
    logic [SH_IW-1:0] sh_idx;
    logic [LG_IW-1:0] lg_idx;
    logic [63:0]      sh_entry;
    logic [63:0]      lg_entry;
    logic [63:0]      dir_base;
    rsp_t             rsp_n;
    rsp_t             rsp_q;
    logic             vld_q;

    dxl_decode #(
        .SH_DEPTH(SH_DEPTH), .LG_DEPTH(LG_DEPTH), .SH_IW(SH_IW), .LG_IW(LG_IW)
    ) u_decode (
        .addr(req_addr), .port(req_port), .dec(dec), .sh_idx(sh_idx), .lg_idx(lg_idx)
    );

    dxl_tables #(
        .SH_DEPTH(SH_DEPTH), .LG_DEPTH(LG_DEPTH), .SH_IW(SH_IW), .LG_IW(LG_IW), .IDX_W(IDX_W)
    ) u_tables (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_tbl(cfg_tbl), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .sh_ridx(sh_idx), .lg_ridx(lg_idx), .port(req_port),
        .sh_entry(sh_entry), .lg_entry(lg_entry), .dir_base(dir_base)
    );

    dxl_compose u_compose (
        .dec(dec), .sh_entry(sh_entry), .lg_entry(lg_entry), .dir_base(dir_base), .rsp(rsp_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            rsp_q <= '{addr: 64'd0, barrier: 1'b0, win: WIN_NONE, fault: 1'b0};
        end else begin
            vld_q <= req_vld;
            if (req_vld) rsp_q <= rsp_n;
        end
    end

    assign rsp_vld     = vld_q;
    assign rsp_addr    = rsp_q.addr;
    assign rsp_barrier = rsp_q.barrier;
    assign rsp_win     = rsp_q.win;
    assign rsp_fault   = rsp_q.fault;

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> rsp_vld) else $error("response missing");  // R10
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_vld |=> !rsp_vld) else $error("spurious response");  // R10
    AST_FAULT_ZEROES: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && rsp_fault) |-> (rsp_addr == 64'd0 && !rsp_barrier)) else $error("fault leaks");  // R9
    AST_WIDE_NO_BARRIER: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && (rsp_win == WIN_P40 || rsp_win == WIN_SUPER)) |-> !rsp_barrier) else $error("barrier in 40-bit");  // R5
    AST_D64_PASS: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_addr[63]) |=> (rsp_fault || rsp_addr == {10'd0, $past(req_addr[53:0])})) else $error("d64 mismatch");  // R1
    AST_NONE_FAULTS: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && rsp_win == WIN_NONE) |-> rsp_fault) else $error("unmatched not faulted");  // R8

endmodule

// File: tb/tb_dxl_top.sv
module tb_dxl_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_vld;
    logic [63:0] req_addr;
    logic        req_port;
    logic        cfg_we;
    logic [1:0]  cfg_tbl;
    logic [6:0]  cfg_idx;
    logic [63:0] cfg_wdata;
    logic        rsp_vld;
    logic [63:0] rsp_addr;
    logic        rsp_barrier;
    logic [2:0]  rsp_win;
    logic        rsp_fault;

    int checks   = 0;
    int failures = 0;

    localparam logic [63:0] V = 64'h8000_0000_0000_0000;

    always #2 clk = ~clk;

    dxl_top dut (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_addr(req_addr), .req_port(req_port),
        .cfg_we(cfg_we), .cfg_tbl(cfg_tbl), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .rsp_vld(rsp_vld), .rsp_addr(rsp_addr), .rsp_barrier(rsp_barrier),
        .rsp_win(rsp_win), .rsp_fault(rsp_fault)
    );

    task automatic chk(input string tag, input logic [63:0] ea, input logic eb,
                       input logic [2:0] ew, input logic ef);
        checks++;
        if (rsp_addr !== ea || rsp_barrier !== eb || rsp_win !== ew || rsp_fault !== ef) begin
            failures++;
            $display("FAIL %s: got addr=%h bar=%0d win=%0d flt=%0d exp addr=%h bar=%0d win=%0d flt=%0d",
                     tag, rsp_addr, rsp_barrier, rsp_win, rsp_fault, ea, eb, ew, ef);
        end
    endtask

    task automatic chk_bit(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %0d exp %0d", tag, got, exp);
        end
    endtask

    task automatic lookup(input logic [63:0] a, input logic p);
        @(negedge clk);
        req_vld = 1'b1; req_addr = a; req_port = p;
        @(negedge clk);
        req_vld = 1'b0;
    endtask

    task automatic wr(input logic [1:0] t, input logic [6:0] i, input logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_tbl = t; cfg_idx = i; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset;
        chk_bit("R10 reset rsp_vld", rsp_vld, 1'b0);
        lookup(64'h0000_0000_0000_0100, 1'b0);
        chk("R12 page entry invalid after reset", 64'd0, 1'b0, 3'd3, 1'b1);
        lookup(64'h0000_0000_8000_1234, 1'b0);
        chk("R12 base zero after reset", 64'h0000_0000_0000_1234, 1'b0, 3'd2, 1'b0);
    endtask

    task automatic t_d64;
        lookup(64'hE03F_1234_5678_9ABC, 1'b0);
        chk("R1 d64 pass with barrier and bit61", 64'h003F_1234_5678_9ABC, 1'b1, 3'd1, 1'b0);
        lookup(64'h8000_0000_0000_0042, 1'b1);
        chk("R1 d64 no barrier", 64'h42, 1'b0, 3'd1, 1'b0);
        lookup(64'h8040_0000_0000_0000, 1'b0);
        chk("R2 d64 reserved bit54", 64'd0, 1'b0, 3'd1, 1'b1);
        lookup(64'hD000_0000_0000_0001, 1'b0);
        chk("R2 R9 d64 reserved bit60 clears barrier", 64'd0, 1'b0, 3'd1, 1'b1);
    endtask

    task automatic t_d32;
        wr(2'd2, 7'd1, 64'h0000_0123_C000_0000);
        lookup(64'h0000_0000_C123_4567, 1'b1);
        chk("R3 d32 port1 splice", 64'h0000_0123_C123_4567, 1'b1, 3'd2, 1'b0);
        lookup(64'h0000_0000_C123_4567, 1'b0);
        chk("R3 d32 port0 separate base", 64'h0000_0000_0123_4567, 1'b1, 3'd2, 1'b0);
    endtask

    task automatic t_p32;
        wr(2'd0, 7'd67, V | 64'h0000_0005_0004_0000);
        lookup(64'h0000_0000_400E_ABCD, 1'b0);
        chk("R4 p32 page3 with barrier", 64'h0000_0005_0006_ABCD, 1'b1, 3'd3, 1'b0);
        lookup(64'h0000_0000_0100_0000, 1'b0);
        chk("R4 p32 page beyond table", 64'd0, 1'b0, 3'd3, 1'b1);
        lookup(64'h0000_0000_0014_0000, 1'b0);
        chk("R7 p32 invalid entry", 64'd0, 1'b0, 3'd3, 1'b1);
    endtask

    task automatic t_p40;
        wr(2'd1, 7'd2, V | 64'h0000_00AB_0C00_0000);
        lookup(64'h0000_0040_0923_4567, 1'b0);
        chk("R5 p40 page2", 64'h0000_00AB_0D23_4567, 1'b0, 3'd4, 1'b0);
        lookup(64'h0000_0041_0000_0000, 1'b0);
        chk("R5 p40 page beyond table", 64'd0, 1'b0, 3'd4, 1'b1);
    endtask

    task automatic t_super;
        wr(2'd0, 7'd33, V | 64'h0000_0C00_0000_0000);
        lookup(64'h0000_0085_2345_6789, 1'b1);
        chk("R6 super port1 page1", 64'h0000_0C01_2345_6789, 1'b0, 3'd5, 1'b0);
        lookup(64'h0000_0085_2345_6789, 1'b0);
        chk("R6 R7 super port0 entry1 invalid", 64'd0, 1'b0, 3'd5, 1'b1);
    endtask

    task automatic t_outside;
        lookup(64'h0000_0001_0000_0000, 1'b0);
        chk("R8 gap below 40-bit window", 64'd0, 1'b0, 3'd0, 1'b1);
        lookup(64'h0100_0000_0000_0000, 1'b1);
        chk("R8 above 40 bits without bit63", 64'd0, 1'b0, 3'd0, 1'b1);
    endtask

    task automatic t_ignore_write;
        wr(2'd3, 7'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        lookup(64'h0000_0000_8000_0010, 1'b0);
        chk("R11 code3 write no effect", 64'h10, 1'b0, 3'd2, 1'b0);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        cfg_we = 1'b1; cfg_tbl = 2'd0; cfg_idx = 7'd71; cfg_wdata = V | 64'h0000_0007_0000_0000;
        req_vld = 1'b1; req_addr = 64'h0000_0000_001C_0155; req_port = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; req_vld = 1'b0;
        chk("R11 same-cycle lookup sees old entry", 64'd0, 1'b0, 3'd3, 1'b1);
        lookup(64'h0000_0000_001C_0155, 1'b0);
        chk("R11 next lookup sees new entry", 64'h0000_0007_0000_0155, 1'b0, 3'd3, 1'b0);
    endtask

    task automatic t_latency;
        lookup(64'h8000_0000_0000_0077, 1'b0);
        chk_bit("R10 valid after request", rsp_vld, 1'b1);
        @(negedge clk);
        chk_bit("R10 valid drops when idle", rsp_vld, 1'b0);
        chk("R10 fields hold when idle", 64'h77, 1'b0, 3'd1, 1'b0);
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; req_vld = 1'b0; req_addr = '0; req_port = 1'b0;
        cfg_we = 1'b0; cfg_tbl = '0; cfg_idx = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_d64();
        t_d32();
        t_p32();
        t_p40();
        t_super();
        t_outside();
        t_ignore_write();
        t_same_cycle();
        t_latency();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule